// File: doc/BRIEF.md
# Receive Descriptor Chain Writer

This block takes received Ethernet frames as a byte stream, one byte per beat, with start-of-frame, end-of-frame and error markers. It places each frame into a receive buffer that is described by a descriptor held in a shared word-addressed memory. It then returns that descriptor to the host with the frame length and status filled in. Descriptors form a linked list. Each descriptor is four consecutive words: word 0 holds status, word 1 holds control, word 2 holds the buffer address and word 3 holds the next-descriptor address. All addresses are word addresses, and the frame bytes are packed little-endian into 32-bit words.

The writer only uses a descriptor that the host has handed over by setting the ownership bit. When it reaches a descriptor the host still owns, it suspends. It stays suspended until a poll-demand strobe makes it read the same descriptor again. Frames that arrive while no descriptor is available are dropped and counted. A receive-done status bit and a transmit-done status bit drive one maskable interrupt line. After a frame ends, the writer needs six clock cycles to write back status and fetch the next descriptor. A frame that starts sooner than that is counted as missed.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset, `suspended_o` is 1, `rx_done_o`, `tx_done_o` and `irq_o` are 0, `missed_o` is 0, and no memory access is made until a poll arrives. The current descriptor pointer is `list_base_i`.
- R2: A poll while suspended reads word 0 at the current pointer. If bit 31 (ownership) is 0, the writer stays suspended. Otherwise it reads word 1 (bit 24 is the chain flag, bits 10:0 are the buffer size in bytes), word 2 (buffer word address) and word 3 (next-descriptor address), and then leaves the suspended state.
- R3: Byte k of a stored frame is written to memory word `buffer + k/4`, in bits `8*(k%4)+7 : 8*(k%4)`. Lanes above the last byte in the final word are written as zero.
- R4: At frame end, word 0 of the descriptor is rewritten with bit 31 = 0, the received byte count in bits 29:16, bit 9 (first segment) = 1 and bit 8 (last segment) = 1. Bit 15 is the error summary, and all other bits are 0.
- R5: The error summary bit is set when `in_err_i` is high on the end-of-frame beat.
- R6: Bytes beyond the buffer size are not written, and no word after the buffer changes. The length field still reports the full received count, and the error summary bit is set.
- R7: When the chain flag is 1, the next descriptor is at the address in word 3. When it is 0, the next descriptor is at the current address + 4.
- R8: A frame whose start beat arrives when no owned descriptor is ready is dropped with no memory write. `missed_o` rises by one per dropped frame and saturates. The writer reports suspended while it waits on a host-owned descriptor.
- R9: `rx_done_o` is set when a descriptor is written back, and it holds until `sts_clr_i[0]` is pulsed.
- R10: `tx_done_o` is set by a `tx_done_i` pulse, and it holds until `sts_clr_i[1]` is pulsed.
- R11: `irq_o` is (`rx_done_o` AND `irq_en_i[0]`) OR (`tx_done_o` AND `irq_en_i[1]`).
- R12: A poll while an owned descriptor is already held causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_base_i | input | AW | Word address of the first descriptor, loaded at reset |
| poll_i | input | 1 | Receive poll-demand strobe |
| in_valid_i | input | 1 | Byte beat valid |
| in_data_i | input | 8 | Received byte |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last byte of a frame |
| in_err_i | input | 1 | Frame error, sampled on the end beat |
| tx_done_i | input | 1 | Transmit-complete pulse |
| sts_clr_i | input | 2 | Write-one-to-clear for status bits (0: receive, 1: transmit) |
| irq_en_i | input | 2 | Interrupt enables (0: receive, 1: transmit) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write when 1, read when 0 |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read request |
| rx_done_o | output | 1 | Receive-done status |
| tx_done_o | output | 1 | Transmit-done status |
| irq_o | output | 1 | Summary interrupt |
| suspended_o | output | 1 | Waiting on a host-owned descriptor |
| missed_o | output | MISS_W | Dropped-frame count |

## Verification
A stale cached descriptor field appears at once in memory. A wrong size lets a write land on the guard word behind the buffer. A wrong buffer address leaves the expected words holding their fill pattern. A wrong next-pointer choice sends the following frame to the wrong buffer. A byte-lane or count slip corrupts the first word of the buffer, or the length field of the status word, within the same frame. An ownership bit that is read wrongly shows up a few cycles after the write-back: either the writer fails to suspend, or it drops a frame that should have been stored, and `missed_o` moves.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    // Descriptor word 0 layout
    localparam int OWN_BIT   = 31;
    localparam int LEN_LSB   = 16;
    localparam int LEN_W     = 14;
    localparam int ES_BIT    = 15;
    localparam int FS_BIT    = 9;
    localparam int LS_BIT    = 8;

    // Descriptor word 1 layout
    localparam int CHAIN_BIT = 24;
    localparam int SIZE_W    = 11;

    localparam int DESC_WORDS = 4;

    typedef enum logic [2:0] {
        ST_SUSP,
        ST_FETCH,
        ST_READY,
        ST_RECV,
        ST_WB
    } seq_state_e;

    typedef struct packed {
        logic              chain;
        logic [SIZE_W-1:0] size;
    } desc_ctl_t;

    // Completed status word: host owns it again, single-buffer frame
    function automatic logic [31:0] status_word(input logic [LEN_W-1:0] len,
                                                input logic es);
        logic [31:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = len;
        w[ES_BIT] = es;
        w[FS_BIT] = 1'b1;
        w[LS_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/rxdw_packer.sv
module rxdw_packer
    import rxdw_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              start,
    input  logic              last,
    input  logic [7:0]        data,
    input  logic [AW-1:0]     buf_base,
    input  logic [SIZE_W-1:0] buf_size,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [31:0]       wr_data,
    output logic [LEN_W-1:0]  len_o,
    output logic              ovf_o
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] eff;
    logic [LEN_W-1:0] size_ext;
    logic [31:0]      pack_q;
    logic [31:0]      merged;
    logic [1:0]       lane;
    logic             stored;
    logic             ovf_q;
    logic [AW-1:0]    words_cap;

    always_comb begin
        eff      = start ? '0 : cnt_q;
        size_ext = LEN_W'(buf_size);
        stored   = eff < size_ext;
        lane     = eff[1:0];
        merged   = start ? '0 : pack_q;
        merged[{lane, 3'b000} +: 8] = data;
        wr_en    = take && stored &&
                   (lane == 2'd3 || last || (eff + LEN_W'(1) == size_ext));
        wr_addr  = buf_base + AW'(eff >> 2);
        wr_data  = merged;
        words_cap = AW'((size_ext + LEN_W'(3)) >> 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pack_q <= '0;
            ovf_q  <= 1'b0;
        end else if (take) begin
            cnt_q  <= (&eff) ? eff : eff + LEN_W'(1);
            pack_q <= (lane == 2'd3) ? '0 : merged;
            ovf_q  <= (start ? 1'b0 : ovf_q) | ~stored;
        end
    end

    assign len_o = cnt_q;
    assign ovf_o = ovf_q;

    // R6: no store lands past the end of the buffer
    p_stay_in_buf_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_addr - buf_base) < words_cap));

    // R6: once a frame overflowed, it stays marked until the next frame
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && take && !start) |=> ovf_q);

endmodule

// File: rtl/rxdw_seq.sv
module rxdw_seq
    import rxdw_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     list_base,
    input  logic              poll,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    output logic              pk_take,
    output logic              pk_start,
    output logic              pk_last,
    input  logic              pk_wr_en,
    input  logic [AW-1:0]     pk_wr_addr,
    input  logic [31:0]       pk_wr_data,
    input  logic [LEN_W-1:0]  pk_len,
    input  logic              pk_ovf,
    output logic [AW-1:0]     buf_base,
    output logic [SIZE_W-1:0] buf_size,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              done_pulse,
    output logic              miss_pulse,
    output logic              suspended
);

    seq_state_e    state_q;
    logic [2:0]    fi_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] buf_q;
    logic [AW-1:0] next_q;
    desc_ctl_t     ctl_q;
    logic          err_q;
    logic [AW-1:0] next_ptr;
    logic          ready_or_recv;
    logic          unused_rdata;

    assign unused_rdata  = ^mem_rdata;
    assign ready_or_recv = (state_q == ST_READY) || (state_q == ST_RECV);

    assign pk_take  = in_valid && (((state_q == ST_READY) && in_sof) || (state_q == ST_RECV));
    assign pk_start = (state_q == ST_READY);
    assign pk_last  = in_eof;

    assign miss_pulse = in_valid && in_sof && !ready_or_recv;
    assign done_pulse = (state_q == ST_WB);
    assign suspended  = (state_q == ST_SUSP);

    assign buf_base = buf_q;
    assign buf_size = ctl_q.size;
    assign next_ptr = ctl_q.chain ? next_q : ptr_q + AW'(DESC_WORDS);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                if (fi_q < 3'(DESC_WORDS)) begin
                    mem_req  = 1'b1;
                    mem_addr = ptr_q + AW'(fi_q);
                end
            end
            ST_READY, ST_RECV: begin
                mem_req   = pk_wr_en;
                mem_we    = 1'b1;
                mem_addr  = pk_wr_addr;
                mem_wdata = pk_wr_data;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q;
                mem_wdata = status_word(pk_len, err_q | pk_ovf);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SUSP;
            fi_q    <= '0;
            ptr_q   <= list_base;
            buf_q   <= '0;
            next_q  <= '0;
            ctl_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_SUSP: begin
                    if (poll) begin
                        state_q <= ST_FETCH;
                        fi_q    <= '0;
                    end
                end
                ST_FETCH: begin
                    fi_q <= fi_q + 3'd1;
                    case (fi_q)
                        3'd1: if (!mem_rdata[OWN_BIT]) state_q <= ST_SUSP;
                        3'd2: begin
                            ctl_q.chain <= mem_rdata[CHAIN_BIT];
                            ctl_q.size  <= mem_rdata[SIZE_W-1:0];
                        end
                        3'd3: buf_q <= mem_rdata[AW-1:0];
                        3'd4: begin
                            next_q  <= mem_rdata[AW-1:0];
                            state_q <= ST_READY;
                        end
                        default: ;
                    endcase
                end
                ST_READY: begin
                    if (pk_take) begin
                        if (in_eof) begin
                            state_q <= ST_WB;
                            err_q   <= in_err;
                        end else begin
                            state_q <= ST_RECV;
                        end
                    end
                end
                ST_RECV: begin
                    if (in_valid && in_eof) begin
                        state_q <= ST_WB;
                        err_q   <= in_err;
                    end
                end
                ST_WB: begin
                    ptr_q   <= next_ptr;
                    state_q <= ST_FETCH;
                    fi_q    <= '0;
                end
                default: state_q <= ST_SUSP;
            endcase
        end
    end

    // R2: a poll in the suspended state starts with a read of the current word 0
    p_poll_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (suspended && poll) |=> (mem_req && !mem_we && mem_addr == $past(ptr_q)));

    // R4: a write-back returns ownership and marks a single-buffer frame
    p_wb_release_r4: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && mem_req && mem_we) |->
        (!mem_wdata[OWN_BIT] && mem_wdata[FS_BIT] && mem_wdata[LS_BIT]));

    // R8: nothing touches memory while waiting on the host
    p_susp_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        suspended |-> !mem_req);

    // R12: a held descriptor is kept while no frame begins
    p_ready_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READY && !(in_valid && in_sof)) |=> (state_q == ST_READY));

endmodule

// File: rtl/rxdw_status.sv
module rxdw_status #(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_set,
    input  logic              tx_set,
    input  logic [1:0]        clr,
    input  logic [1:0]        en,
    input  logic              miss_inc,
    output logic              rx_sts,
    output logic              tx_sts,
    output logic              irq,
    output logic [MISS_W-1:0] missed
);

    logic [1:0] sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '0;
            missed <= '0;
        end else begin
            sts_q[0] <= rx_set | (sts_q[0] & ~clr[0]);
            sts_q[1] <= tx_set | (sts_q[1] & ~clr[1]);
            if (miss_inc && !(&missed))
                missed <= missed + MISS_W'(1);
        end
    end

    assign rx_sts = sts_q[0];
    assign tx_sts = sts_q[1];
    assign irq    = |(sts_q & en);

    // R9: a completed frame always raises the receive status
    p_rx_set_r9: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> rx_sts);

    // R10: transmit status holds until cleared
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_sts && !clr[1]) |=> tx_sts);

    // R11: with both enables low the line stays quiet
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (en == 2'b00) |-> !irq);

    // R8: the dropped-frame count never goes down
    p_missed_mono_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (missed >= $past(missed)));

endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
    import rxdw_pkg::*;
#(
    parameter int AW     = 16,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     list_base_i,
    input  logic              poll_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_sof_i,
    input  logic              in_eof_i,
    input  logic              in_err_i,
    input  logic              tx_done_i,
    input  logic [1:0]        sts_clr_i,
    input  logic [1:0]        irq_en_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic              rx_done_o,
    output logic              tx_done_o,
    output logic              irq_o,
    output logic              suspended_o,
    output logic [MISS_W-1:0] missed_o
);

    logic              pk_take;
    logic              pk_start;
    logic              pk_last;
    logic              pk_wr_en;
    logic [AW-1:0]     pk_wr_addr;
    logic [31:0]       pk_wr_data;
    logic [LEN_W-1:0]  pk_len;
    logic              pk_ovf;
    logic [AW-1:0]     buf_base;
    logic [SIZE_W-1:0] buf_size;
    logic              done_pulse;
    logic              miss_pulse;

    rxdw_packer #(.AW(AW)) u_packer (
        .clk      (clk),
        .rst      (rst),
        .take     (pk_take),
        .start    (pk_start),
        .last     (pk_last),
        .data     (in_data_i),
        .buf_base (buf_base),
        .buf_size (buf_size),
        .wr_en    (pk_wr_en),
        .wr_addr  (pk_wr_addr),
        .wr_data  (pk_wr_data),
        .len_o    (pk_len),
        .ovf_o    (pk_ovf)
    );

    rxdw_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .list_base  (list_base_i),
        .poll       (poll_i),
        .in_valid   (in_valid_i),
        .in_sof     (in_sof_i),
        .in_eof     (in_eof_i),
        .in_err     (in_err_i),
        .pk_take    (pk_take),
        .pk_start   (pk_start),
        .pk_last    (pk_last),
        .pk_wr_en   (pk_wr_en),
        .pk_wr_addr (pk_wr_addr),
        .pk_wr_data (pk_wr_data),
        .pk_len     (pk_len),
        .pk_ovf     (pk_ovf),
        .buf_base   (buf_base),
        .buf_size   (buf_size),
        .mem_req    (mem_req_o),
        .mem_we     (mem_we_o),
        .mem_addr   (mem_addr_o),
        .mem_wdata  (mem_wdata_o),
        .mem_rdata  (mem_rdata_i),
        .done_pulse (done_pulse),
        .miss_pulse (miss_pulse),
        .suspended  (suspended_o)
    );

    rxdw_status #(.MISS_W(MISS_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .rx_set   (done_pulse),
        .tx_set   (tx_done_i),
        .clr      (sts_clr_i),
        .en       (irq_en_i),
        .miss_inc (miss_pulse),
        .rx_sts   (rx_done_o),
        .tx_sts   (tx_done_o),
        .irq      (irq_o),
        .missed   (missed_o)
    );

endmodule

// File: tb/tb_rx_desc_writer.sv
`timescale 1ns/1ps
module tb_rx_desc_writer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] list_base = 16'h0000;
    logic        poll = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_err = 1'b0;
    logic        tx_done = 1'b0;
    logic [1:0]  sts_clr = 2'b00;
    logic [1:0]  irq_en = 2'b00;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        rx_done_s;
    logic        tx_done_s;
    logic        irq;
    logic        suspended;
    logic [15:0] missed;

    logic [31:0] mem [0:255];
    logic [7:0]  fb  [0:127];
    int checks = 0;
    int failures = 0;
    int acc_cnt = 0;

    always #2.5 clk = ~clk;

    rx_desc_writer dut (
        .clk(clk), .rst(rst), .list_base_i(list_base), .poll_i(poll),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_sof_i(in_sof),
        .in_eof_i(in_eof), .in_err_i(in_err), .tx_done_i(tx_done),
        .sts_clr_i(sts_clr), .irq_en_i(irq_en), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .rx_done_o(rx_done_s), .tx_done_o(tx_done_s),
        .irq_o(irq), .suspended_o(suspended), .missed_o(missed)
    );

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            acc_cnt = acc_cnt + 1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    function automatic logic [31:0] fillv(input int a);
        return 32'hA5A5_0000 | 32'(a);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic new_bytes();
        for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
    endtask

    task automatic refill(input int a, input int n);
        for (int i = a; i < a + n; i++) mem[i] = fillv(i);
    endtask

    task automatic set_desc(input int a, input bit own, input bit chain,
                            input int size, input int bufa, input int nxt);
        mem[a]   = own ? 32'h8000_0000 : 32'h0;
        mem[a+1] = (chain ? 32'h0100_0000 : 32'h0) | 32'(size);
        mem[a+2] = 32'(bufa);
        mem[a+3] = 32'(nxt);
    endtask

    task automatic send(input int len, input bit err);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb[k];
            in_sof   = (k == 0);
            in_eof   = (k == len - 1);
            in_err   = err && (k == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
        tick(10);
    endtask

    task automatic do_poll();
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        tick(10);
    endtask

    // Expected memory image of one completed frame (R3, R4, R5, R6)
    task automatic check_frame(input string req, input int d, input int bufa,
                               input int size, input int len, input bit err);
        int stored;
        int nw;
        logic [31:0] w0;
        logic [31:0] ew;
        stored = (len < size) ? len : size;
        nw = (stored + 3) / 4;
        w0 = (32'(len) << 16) | 32'h0000_0300;
        if (err || len > size) w0 = w0 | 32'h0000_8000;
        chk({req, " status word"}, mem[d], w0);
        for (int w = 0; w < nw; w++) begin
            ew = '0;
            for (int b = 0; b < 4; b++)
                if (w * 4 + b < stored) ew[b*8 +: 8] = fb[w * 4 + b];
            chk({req, " R3 data word"}, mem[bufa + w], ew);
        end
        chk({req, " R6 guard word"}, mem[bufa + nw], fillv(bufa + nw));
    endtask

    initial begin
        int a0;
        int len;
        bit err;
        void'($urandom(32'h1234_5eed));
        for (int i = 0; i < 256; i++) mem[i] = fillv(i);
        // d0 -> (chain) 0x20 ; d1 at 0x20 unchained -> 0x24 ; d2 -> 0x00
        set_desc(8'h00, 1, 1, 16, 8'h40, 8'h20);
        set_desc(8'h20, 1, 0, 8,  8'h50, 8'hEE);
        set_desc(8'h24, 1, 1, 64, 8'h60, 8'h00);
        set_desc(8'h30, 0, 1, 40, 8'h80, 8'h30);
        tick(4);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        chk("R1 suspended", 32'(suspended), 32'd1);
        chk("R1 rx_done", 32'(rx_done_s), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 missed", 32'(missed), 32'd0);
        chk("R1 no memory access", 32'(acc_cnt), 32'd0);

        // R8 frame before any descriptor is fetched is dropped
        new_bytes();
        send(6, 0);
        chk("R8 missed after drop", 32'(missed), 32'd1);
        chk("R8 buffer untouched", mem[8'h40], fillv(8'h40));
        chk("R8 no access on drop", 32'(acc_cnt), 32'd0);

        // R2 poll fetches owned d0
        do_poll();
        chk("R2 left suspend", 32'(suspended), 32'd0);
        chk("R2 four reads", 32'(acc_cnt), 32'd4);

        // R12 poll while holding a descriptor
        a0 = acc_cnt;
        do_poll();
        chk("R12 no access on redundant poll", 32'(acc_cnt), 32'(a0));

        // R3 R4 normal frame into d0
        new_bytes();
        send(13, 0);
        check_frame("R4 frame d0", 8'h00, 8'h40, 16, 13, 0);
        chk("R9 rx_done set", 32'(rx_done_s), 32'd1);
        @(negedge clk); irq_en = 2'b01; @(negedge clk);
        chk("R11 irq rx enabled", 32'(irq), 32'd1);
        irq_en = 2'b10; @(negedge clk);
        chk("R11 irq rx masked", 32'(irq), 32'd0);
        sts_clr = 2'b01; @(negedge clk); sts_clr = 2'b00; @(negedge clk);
        chk("R9 rx_done cleared", 32'(rx_done_s), 32'd0);

        // R6 R7 overflow into d1 reached through word 3 of d0
        new_bytes();
        send(11, 0);
        check_frame("R6 R7 overflow d1", 8'h20, 8'h50, 8, 11, 0);

        // R5 R7 error frame into d2 reached by +4 (chain flag clear)
        new_bytes();
        len = 20 + int'($urandom_range(40));
        send(len, 1);
        check_frame("R5 R7 error d2", 8'h24, 8'h60, 64, len, 1);

        // R2 R8 chain returns to d0 which is now host-owned
        chk("R2 suspended on host-owned", 32'(suspended), 32'd1);
        a0 = acc_cnt;
        new_bytes();
        send(5, 0);
        chk("R8 missed second drop", 32'(missed), 32'd2);
        chk("R8 no write on drop", 32'(acc_cnt), 32'(a0));

        // One-byte frame (start and end on the same beat)
        set_desc(8'h00, 1, 1, 16, 8'h40, 8'h30);
        refill(8'h40, 8);
        do_poll();
        new_bytes();
        send(1, 0);
        check_frame("R3 R4 single byte", 8'h00, 8'h40, 16, 1, 0);
        chk("R8 suspended at d3", 32'(suspended), 32'd1);

        // Constrained random frames through a self-chained descriptor
        for (int it = 0; it < 14; it++) begin
            len = 1 + int'($urandom_range(49));
            err = ($urandom_range(3) == 0);
            set_desc(8'h30, 1, 1, 40, 8'h80, 8'h30);
            refill(8'h80, 16);
            do_poll();
            new_bytes();
            send(len, err);
            check_frame("R3 R4 R5 R6 random", 8'h30, 8'h80, 40, len, err);
            chk("R7 R8 self chain suspends", 32'(suspended), 32'd1);
        end

        // R10 R11 transmit status
        @(negedge clk); sts_clr = 2'b01; tx_done = 1'b1;
        @(negedge clk); sts_clr = 2'b00; tx_done = 1'b0; irq_en = 2'b10;
        @(negedge clk);
        chk("R10 tx_done set", 32'(tx_done_s), 32'd1);
        chk("R11 irq tx enabled", 32'(irq), 32'd1);
        irq_en = 2'b00; @(negedge clk);
        chk("R11 irq all masked", 32'(irq), 32'd0);
        tick(3);
        chk("R10 tx_done held", 32'(tx_done_s), 32'd1);
        sts_clr = 2'b10; @(negedge clk); sts_clr = 2'b00; @(negedge clk);
        chk("R10 tx_done cleared", 32'(tx_done_s), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule